// File: doc/BRIEF.md
# UART Interrupt Output Generator

This block drives the active-low interrupt pin of a UART from two service sources: the transmitter and the receiver. It does not hold any data. The FIFO and shift logic sit outside it and report only their occupancy levels, the programmed trigger levels and a flag that says the transmit shift register is empty. From these inputs the block decides whether each side needs service. The decision depends on two control bits: one enables the FIFOs and the other turns on automatic half-duplex direction control. When automatic direction control is on, the transmit side waits for the whole transmitter to drain, shift register included, before it asks for more data.

Each source has its own enable. The enabled requests are combined into one request, and that request is registered on the system clock, so the pin cannot glitch. The pin is low whenever any enabled source wants service. In single-byte mode, a transmit level of 0 means the holding register is empty and any nonzero level means it holds a byte.

Top module: `uart_irq_gen`

## Requirements
- R1: While rst_ni is low, irq_no is high. After reset is released, irq_no stays high until a clock edge samples an enabled request.
- R2: With fifo_en_i=0 and auto_dir_i=0, the transmit side requests service exactly when tx_lvl_i is 0. The value of tsr_empty_i is ignored.
- R3: With fifo_en_i=1 and auto_dir_i=0, the transmit side requests service when tx_lvl_i < tx_trig_i or tx_lvl_i is 0. It does not request when tx_lvl_i >= tx_trig_i and tx_lvl_i is nonzero.
- R4: With fifo_en_i=0 and auto_dir_i=1, the transmit side requests service only when tx_lvl_i is 0 and tsr_empty_i=1.
- R5: With fifo_en_i=1 and auto_dir_i=1, the transmit side requests service when tx_lvl_i < tx_trig_i, or when tx_lvl_i is 0 and tsr_empty_i=1. An empty FIFO with a busy shift register and tx_trig_i=0 does not request.
- R6: With fifo_en_i=0, the receive side requests service exactly when rx_lvl_i is nonzero.
- R7: With fifo_en_i=1, the receive side requests service when rx_lvl_i >= rx_trig_i and rx_lvl_i is nonzero.
- R8: A source whose enable (tx_ie_i or rx_ie_i) is 0 never pulls irq_no low.
- R9: irq_no is low when at least one enabled source requests service and high when none does.
- R10: irq_no shows the inputs sampled at the previous rising edge of clk_i. A change in the inputs between edges does not move irq_no.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fifo_en_i | input | 1 | FIFO mode enable |
| auto_dir_i | input | 1 | Automatic half-duplex direction control enable |
| tx_lvl_i | input | LVL_W | Transmit holding/FIFO occupancy |
| tx_trig_i | input | LVL_W | Transmit trigger level |
| tsr_empty_i | input | 1 | Transmit shift register empty |
| rx_lvl_i | input | LVL_W | Receive occupancy |
| rx_trig_i | input | LVL_W | Receive trigger level |
| tx_ie_i | input | 1 | Transmit interrupt enable |
| rx_ie_i | input | 1 | Receive interrupt enable |
| irq_no | output | 1 | Interrupt output, active low |

## Verification
The bench builds the block with DEPTH=16, so LVL_W is 5. At that size the level inputs can reach a full FIFO, a trigger of zero and a trigger equal to the depth with only a few vectors. The bench uses trigger values of 4 and 8 to place the threshold inside the FIFO. It then checks the levels on both sides of each threshold. Under automatic direction control it also checks the case of an empty FIFO with a busy shift register.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  typedef enum logic [1:0] {
    TXM_HOLD       = 2'b00,
    TXM_FIFO       = 2'b01,
    TXM_DRAIN      = 2'b10,
    TXM_FIFO_DRAIN = 2'b11
  } tx_mode_e;

  function automatic tx_mode_e tx_mode(input logic fifo_en, input logic auto_dir);
    return tx_mode_e'({auto_dir, fifo_en});
  endfunction
endpackage

// File: rtl/uart_irq_tx_cond.sv
module uart_irq_tx_cond
  import uart_irq_pkg::*;
#(
  parameter int LVL_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  tx_mode_e         mode_i,
  input  logic [LVL_W-1:0] lvl_i,
  input  logic [LVL_W-1:0] trig_i,
  input  logic             tsr_empty_i,
  output logic             req_o
);
  logic empty, below;

  assign empty = (lvl_i == '0);
  assign below = (lvl_i < trig_i);

  always_comb begin
    unique case (mode_i)
      TXM_HOLD:       req_o = empty;
      TXM_FIFO:       req_o = below || empty;
      TXM_DRAIN:      req_o = empty && tsr_empty_i;
      TXM_FIFO_DRAIN: req_o = below || (empty && tsr_empty_i);
      default:        req_o = 1'b0;
    endcase
  end

  // R4: drain mode never requests while the shift register is busy
  assert_drain_waits_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == TXM_DRAIN && !tsr_empty_i) |-> !req_o);
  // R3: a FIFO at or above its nonzero trigger gives no request
  assert_fifo_full_quiet_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == TXM_FIFO && lvl_i != '0 && lvl_i >= trig_i) |-> !req_o);
endmodule

// File: rtl/uart_irq_rx_cond.sv
module uart_irq_rx_cond #(
  parameter int LVL_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fifo_en_i,
  input  logic [LVL_W-1:0] lvl_i,
  input  logic [LVL_W-1:0] trig_i,
  output logic             req_o
);
  logic has_data;

  assign has_data = (lvl_i != '0);
  assign req_o    = has_data && (!fifo_en_i || (lvl_i >= trig_i));

  // R6: single-byte mode requests on any received byte
  assert_rx_byte_req_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fifo_en_i && lvl_i != '0) |-> req_o);
  // R7: an empty receiver never requests
  assert_rx_empty_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lvl_i == '0) |-> !req_o);
endmodule

// File: rtl/uart_irq_out.sv
module uart_irq_out #(
  parameter int N_SRC = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] req_i,
  input  logic [N_SRC-1:0] en_i,
  output logic             irq_no
);
  logic [N_SRC-1:0] gated;
  logic             irq_q;

  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    assign gated[g] = req_i[g] & en_i[g];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b1;
    else         irq_q <= ~(|gated);
  end

  assign irq_no = irq_q;

  // R8: all sources masked keeps the pin inactive on the next cycle
  assert_masked_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i == '0) |=> irq_no);
  // R10: a low pin was caused by an enable sampled one edge earlier
  assert_low_has_cause_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_no |-> $past(en_i != '0));
endmodule

// File: rtl/uart_irq_gen.sv
module uart_irq_gen
  import uart_irq_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fifo_en_i,
  input  logic             auto_dir_i,
  input  logic [LVL_W-1:0] tx_lvl_i,
  input  logic [LVL_W-1:0] tx_trig_i,
  input  logic             tsr_empty_i,
  input  logic [LVL_W-1:0] rx_lvl_i,
  input  logic [LVL_W-1:0] rx_trig_i,
  input  logic             tx_ie_i,
  input  logic             rx_ie_i,
  output logic             irq_no
);
  localparam int N_SRC  = 2;
  localparam int SRC_TX = 0;
  localparam int SRC_RX = 1;

  logic [N_SRC-1:0] req, en;

  uart_irq_tx_cond #(.LVL_W(LVL_W)) u_tx (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .mode_i      (tx_mode(fifo_en_i, auto_dir_i)),
    .lvl_i       (tx_lvl_i),
    .trig_i      (tx_trig_i),
    .tsr_empty_i (tsr_empty_i),
    .req_o       (req[SRC_TX])
  );

  uart_irq_rx_cond #(.LVL_W(LVL_W)) u_rx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .fifo_en_i (fifo_en_i),
    .lvl_i     (rx_lvl_i),
    .trig_i    (rx_trig_i),
    .req_o     (req[SRC_RX])
  );

  assign en[SRC_TX] = tx_ie_i;
  assign en[SRC_RX] = rx_ie_i;

  uart_irq_out #(.N_SRC(N_SRC)) u_out (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (req),
    .en_i   (en),
    .irq_no (irq_no)
  );

  // R9: an enabled received byte in single-byte mode pulls the pin low next cycle
  assert_rx_pulls_low_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_ie_i && !fifo_en_i && rx_lvl_i != '0) |=> !irq_no);
endmodule

// File: tb/sim_uart_irq_gen.sv
module sim_uart_irq_gen;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;
  localparam int LVL_W = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fifo_en = 1'b0, auto_dir = 1'b0, tsr_empty = 1'b0, tx_ie = 1'b0, rx_ie = 1'b0;
  logic [LVL_W-1:0] tx_lvl = '0, tx_trig = '0, rx_lvl = '0, rx_trig = '0;
  logic irq_n;
  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_irq_gen #(.DEPTH(DEPTH)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .fifo_en_i(fifo_en), .auto_dir_i(auto_dir),
    .tx_lvl_i(tx_lvl), .tx_trig_i(tx_trig), .tsr_empty_i(tsr_empty),
    .rx_lvl_i(rx_lvl), .rx_trig_i(rx_trig), .tx_ie_i(tx_ie), .rx_ie_i(rx_ie),
    .irq_no(irq_n)
  );

  task automatic check(input logic exp, input string tag);
    n_chk++;
    if (irq_n !== exp) begin
      n_fail++;
      $display("FAIL %s: irq_no=%b expected %b", tag, irq_n, exp);
    end
  endtask

  // drive at negedge, let one rising edge pass, sample at following negedge
  task automatic apply(input logic fe, input logic ad, input int txl, input int txt,
                       input logic tsr, input int rxl, input int rxt,
                       input logic txe, input logic rxe);
    @(negedge clk);
    fifo_en = fe; auto_dir = ad; tx_lvl = LVL_W'(txl); tx_trig = LVL_W'(txt);
    tsr_empty = tsr; rx_lvl = LVL_W'(rxl); rx_trig = LVL_W'(rxt);
    tx_ie = txe; rx_ie = rxe;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    fifo_en = 1'b0; tx_lvl = '0; tx_ie = 1'b1; rx_ie = 1'b1; rx_lvl = 5'd3;
    repeat (3) @(negedge clk);
    check(1'b1, "R1 in reset");
    rst_n = 1'b1;
    #1 check(1'b1, "R1 after release before edge");
    apply(0, 0, 1, 0, 0, 0, 0, 0, 0);
    check(1'b1, "R1 idle after reset");
  endtask

  task automatic t_hold;
    apply(0, 0, 0, 0, 0, 0, 0, 1, 0); check(1'b0, "R2 holding empty");
    apply(0, 0, 1, 0, 1, 0, 0, 1, 0); check(1'b1, "R2 holding full");
    apply(0, 0, 0, 0, 1, 0, 0, 1, 0); check(1'b0, "R2 tsr ignored");
  endtask

  task automatic t_fifo;
    apply(1, 0, 3, 4, 0, 0, 0, 1, 0);  check(1'b0, "R3 below trigger");
    apply(1, 0, 4, 4, 0, 0, 0, 1, 0);  check(1'b1, "R3 at trigger");
    apply(1, 0, 16, 4, 1, 0, 0, 1, 0); check(1'b1, "R3 full");
    apply(1, 0, 0, 0, 0, 0, 0, 1, 0);  check(1'b0, "R3 empty trig zero");
  endtask

  task automatic t_drain;
    apply(0, 1, 0, 0, 0, 0, 0, 1, 0); check(1'b1, "R4 shifter busy");
    apply(0, 1, 0, 0, 1, 0, 0, 1, 0); check(1'b0, "R4 fully empty");
    apply(0, 1, 1, 0, 1, 0, 0, 1, 0); check(1'b1, "R4 holding full");
  endtask

  task automatic t_fifo_drain;
    apply(1, 1, 3, 4, 0, 0, 0, 1, 0); check(1'b0, "R5 below trigger");
    apply(1, 1, 5, 4, 1, 0, 0, 1, 0); check(1'b1, "R5 above trigger");
    apply(1, 1, 0, 0, 0, 0, 0, 1, 0); check(1'b1, "R5 empty fifo busy shifter");
    apply(1, 1, 0, 0, 1, 0, 0, 1, 0); check(1'b0, "R5 transmitter empty");
  endtask

  task automatic t_rx;
    apply(0, 0, 1, 0, 0, 0, 0, 0, 1);  check(1'b1, "R6 no data");
    apply(0, 0, 1, 0, 0, 1, 8, 0, 1);  check(1'b0, "R6 one byte");
    apply(1, 0, 1, 0, 0, 7, 8, 0, 1);  check(1'b1, "R7 below trigger");
    apply(1, 0, 1, 0, 0, 8, 8, 0, 1);  check(1'b0, "R7 at trigger");
    apply(1, 0, 1, 0, 0, 16, 8, 0, 1); check(1'b0, "R7 full");
    apply(1, 0, 1, 0, 0, 0, 0, 0, 1);  check(1'b1, "R7 empty trig zero");
  endtask

  task automatic t_enables;
    apply(0, 0, 0, 0, 1, 1, 0, 0, 0); check(1'b1, "R8 both masked");
    apply(0, 0, 0, 0, 1, 1, 0, 1, 0); check(1'b0, "R8 tx only enabled");
    apply(0, 0, 1, 0, 1, 1, 0, 1, 0); check(1'b1, "R8 rx masked");
    apply(0, 0, 1, 0, 1, 1, 0, 1, 1); check(1'b0, "R9 rx alone");
    apply(0, 0, 1, 0, 1, 0, 0, 1, 1); check(1'b1, "R9 no request");
  endtask

  task automatic t_latency;
    apply(0, 0, 1, 0, 0, 0, 0, 1, 1); check(1'b1, "R10 start high");
    tx_lvl = '0;
    #1 check(1'b1, "R10 no change before edge");
    @(posedge clk); #1 check(1'b0, "R10 low after edge");
    @(negedge clk); tx_lvl = 5'd1;
    #1 check(1'b0, "R10 held before edge");
    @(posedge clk); #1 check(1'b1, "R10 high after edge");
  endtask

  initial begin
    fork
      begin
        t_reset(); t_hold(); t_fifo(); t_drain(); t_fifo_drain();
        t_rx(); t_enables(); t_latency();
      end
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: run incomplete, expected completion");
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule